// File: doc/BRIEF.md
# Program Bank Mapper and Start Gate

This block sits beside a small graphics coprocessor and performs two jobs. First, it turns an 8-bit bank number and a 16-bit offset into a physical address inside a flat ROM image or a separate work RAM. It also flags which of the two memories the address belongs to. ROM banks with reduced value 0x40 or higher are laid out as plain 64 KB pages. Lower banks fold into a second region that begins one page past the largest legal ROM size. Four bank numbers are reserved for work RAM, and they alias onto however many RAM pages are fitted.

Second, when the host asks the coprocessor to start, the block decides whether execution may begin at the current program bank and counter. The answer depends on three things: whether the counter falls inside the active instruction cache window, which bank range the program bank falls in, and the two memory-enable bits of the screen mode register. A refused start produces a one-cycle pulse that clears the go flag. A granted start produces a one-cycle pulse that clears the IRQ flag. Address lookups and start verdicts each take one request cycle and answer on the next clock.

Top module: `prog_bank_mapper`

## Requirements
- R1: A request whose bank has bit 6 set (reduced value 0x40 and up) and is not a RAM bank returns physical page (reduced bank mod ROM count), with `map_is_ram` = 0. The physical address is page × 0x10000 + offset.
- R2: With an effective ROM count of 1, such a high bank maps to page = bank bit 0.
- R3: A request whose reduced bank is below 0x40 returns page 0x20 + (reduced bank mod 2 × ROM count), with `map_is_ram` = 0. Page 0x20 corresponds to physical address 0x200000.
- R4: Bank bit 7 is ignored for ROM mapping. For example, bank 0xC5 maps exactly as 0x45 does, and bank 0xF1 maps to ROM as 0x71 would when treated as ROM.
- R5: The ROM count input is clamped to the range 1 to 32. A value of 0 acts as 1, and any value above 32 acts as 32.
- R6: Full banks 0x70 to 0x73 return page ((bank − 0x70) mod RAM count) with `map_is_ram` = 1. The RAM count is clamped to the range 1 to 4.
- R7: `map_vld` pulses exactly one cycle after `map_req`. `map_addr` and `map_is_ram` are updated on that edge, and the low 16 address bits equal the request offset.
- R8: When `cache_on` = 1 and `cache_base` ≤ `st_pc` < `cache_base` + 512, with the comparison done without 16-bit wrap, the start is granted for any bank and any enable bits.
- R9: Outside the cache window, a start is refused for program banks 0x60 to 0x6F and for banks 0x74 to 0xFF.
- R10: Outside the cache window, a start at banks 0x70 to 0x73 is granted only if `scr_ram_en` = 1. A start at any other bank is granted only if `scr_rom_en` = 1.
- R11: One cycle after `st_req`, `st_vld` = 1. A grant gives `st_ok` = 1, `irq_clr` = 1 and `go_clr` = 0. A refusal gives `st_ok` = 0, `go_clr` = 1 and `irq_clr` = 0. In cycles that follow no request, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_bank_cnt | input | 6 | Configured number of 64 KB ROM pages |
| ram_bank_cnt | input | 3 | Configured number of 64 KB RAM pages |
| map_req | input | 1 | Address lookup request |
| map_bank | input | 8 | Bank number to translate |
| map_offset | input | 16 | Offset within the bank |
| map_vld | output | 1 | Lookup result valid |
| map_addr | output | 23 | Physical address |
| map_is_ram | output | 1 | 1 when the address targets work RAM |
| st_req | input | 1 | Start verdict request |
| st_bank | input | 8 | Program bank at start |
| st_pc | input | 16 | Program counter at start |
| cache_base | input | 16 | Instruction cache base address |
| cache_on | input | 1 | Instruction cache holds valid code |
| scr_rom_en | input | 1 | Screen mode ROM-enable bit |
| scr_ram_en | input | 1 | Screen mode RAM-enable bit |
| st_vld | output | 1 | Start verdict valid |
| st_ok | output | 1 | Start granted |
| go_clr | output | 1 | Pulse: clear the go flag |
| irq_clr | output | 1 | Pulse: clear the IRQ flag |

## Verification
Both results come out of one register stage. The address, RAM select and verdict are therefore due on the first rising edge after the request is sampled. The bench drives a request just after a falling edge and reads the outputs at the next falling edge, which is half a period after that one edge. It then drops the request and reads again one cycle later, to confirm that the valid and pulse outputs return to zero and do not linger.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  // Memory region a lookup lands in
  typedef enum logic [1:0] {
    REG_ROM_HI = 2'd0,
    REG_ROM_LO = 2'd1,
    REG_RAM    = 2'd2
  } region_e;

  // Outcome of a start check
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_GRANT = 2'd1,
    VERD_DENY  = 2'd2
  } verdict_e;

  // Inclusive range test on a bank number
  function automatic logic bank_in(input logic [7:0] b, input logic [7:0] lo,
                                   input logic [7:0] hi);
    return (b >= lo) && (b <= hi);
  endfunction
endpackage

// File: rtl/pbm_rem_div.sv
// Combinational remainder via a restoring long-division chain
module pbm_rem_div #(
  parameter int W = 7
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] remainder
);
  logic [W:0] part [W+1];

  assign part[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_step
    logic [W:0] shifted;
    assign shifted   = {part[g][W-1:0], dividend[W-1-g]};
    assign part[g+1] = (shifted >= {1'b0, divisor}) ? (shifted - {1'b0, divisor}) : shifted;
  end

  assign remainder = part[W][W-1:0];
endmodule

// File: rtl/pbm_addr_map.sv
module pbm_addr_map
  import pbm_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int OFF_W     = 16,
  parameter int ROM_CNT_W = 6,
  parameter int RAM_CNT_W = 3,
  parameter int ROM_MAX   = 32,
  parameter int RAM_MAX   = 4,
  parameter int RAM_FIRST = 'h70,
  localparam int RED_W    = BANK_W - 1,
  localparam int PB_W     = $clog2(2 * ROM_MAX) + 1,
  localparam int PHYS_W   = OFF_W + PB_W,
  localparam int RM_W     = $clog2(RAM_MAX) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROM_CNT_W-1:0] rom_cnt,
  input  logic [RAM_CNT_W-1:0] ram_cnt,
  input  logic                 req,
  input  logic [BANK_W-1:0]    bank,
  input  logic [OFF_W-1:0]     offset,
  output logic                 vld,
  output logic [PHYS_W-1:0]    addr,
  output logic                 is_ram
);
  localparam logic [PHYS_W-1:0] LO_BASE = PHYS_W'(ROM_MAX) << OFF_W;

  // Effective counts after clamping
  logic [RED_W-1:0] rom_n;
  logic [RED_W-1:0] rom_n2;
  logic [RM_W-1:0]  ram_n;

  always_comb begin
    if (rom_cnt == '0)                rom_n = RED_W'(1);
    else if (int'(rom_cnt) > ROM_MAX) rom_n = RED_W'(ROM_MAX);
    else                              rom_n = RED_W'(rom_cnt);
    if (ram_cnt == '0)                ram_n = RM_W'(1);
    else if (int'(ram_cnt) > RAM_MAX) ram_n = RM_W'(RAM_MAX);
    else                              ram_n = RM_W'(ram_cnt);
  end

  assign rom_n2 = rom_n << 1;

  logic [RED_W-1:0] red;
  logic [RED_W-1:0] rem_hi;
  logic [RED_W-1:0] rem_lo;
  logic [RM_W-1:0]  ram_off;
  logic [RM_W-1:0]  rem_ram;

  assign red     = bank[RED_W-1:0];
  assign ram_off = RM_W'(bank - BANK_W'(RAM_FIRST));

  pbm_rem_div #(.W(RED_W)) u_rem_hi (.dividend(red), .divisor(rom_n),  .remainder(rem_hi));
  pbm_rem_div #(.W(RED_W)) u_rem_lo (.dividend(red), .divisor(rom_n2), .remainder(rem_lo));
  pbm_rem_div #(.W(RM_W))  u_rem_rm (.dividend(ram_off), .divisor(ram_n), .remainder(rem_ram));

  region_e        region;
  logic [PB_W-1:0] page;

  always_comb begin
    if ((int'(bank) >= RAM_FIRST) && (int'(bank) < RAM_FIRST + RAM_MAX))
      region = REG_RAM;
    else if (red[RED_W-1])
      region = REG_ROM_HI;
    else
      region = REG_ROM_LO;

    unique case (region)
      REG_RAM:    page = PB_W'(rem_ram);
      REG_ROM_HI: page = (rom_n == RED_W'(1)) ? PB_W'(red[0]) : PB_W'(rem_hi);
      default:    page = PB_W'(ROM_MAX) + PB_W'(rem_lo);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      addr   <= '0;
      is_ram <= 1'b0;
    end else begin
      vld <= req;
      if (req) begin
        addr   <= {page, offset};
        is_ram <= (region == REG_RAM);
      end
    end
  end

  // R7
  map_lat_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> vld && (addr[OFF_W-1:0] == $past(offset)));
  // R7
  map_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !vld);
  // R3
  lo_region_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !bank[RED_W-1]) |=> (!is_ram && addr >= LO_BASE));
  // R1
  hi_region_chk: assert property (@(posedge clk) disable iff (rst)
    (req && bank[RED_W-1] && !is_ram_bank_q(bank)) |=> (!is_ram && addr < LO_BASE));
  // R6
  ram_page_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && is_ram) |-> (int'(addr[PHYS_W-1:OFF_W]) < RAM_MAX));

  function automatic logic is_ram_bank_q(input logic [BANK_W-1:0] b);
    return (int'(b) >= RAM_FIRST) && (int'(b) < RAM_FIRST + RAM_MAX);
  endfunction
endmodule

// File: rtl/pbm_start_gate.sv
module pbm_start_gate
  import pbm_pkg::*;
#(
  parameter int BANK_W      = 8,
  parameter int OFF_W       = 16,
  parameter int CACHE_BYTES = 512,
  parameter int RAM_FIRST   = 'h70,
  parameter int RAM_MAX     = 4,
  parameter int VOID_LO     = 'h60,
  parameter int VOID_HI     = 'h6F,
  localparam int RAM_LAST   = RAM_FIRST + RAM_MAX - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  pc,
  input  logic [OFF_W-1:0]  cbase,
  input  logic              cache_on,
  input  logic              rom_en,
  input  logic              ram_en,
  output logic              vld,
  output logic              ok,
  output logic              go_clr,
  output logic              irq_clr
);
  logic [OFF_W:0] pc_x;
  logic [OFF_W:0] lo_x;
  logic [OFF_W:0] hi_x;
  logic           in_window;
  logic           in_void;
  logic           in_ram;
  logic           above_ram;
  verdict_e       verdict;

  assign pc_x      = {1'b0, pc};
  assign lo_x      = {1'b0, cbase};
  assign hi_x      = lo_x + (OFF_W+1)'(CACHE_BYTES);
  assign in_window = cache_on && (pc_x >= lo_x) && (pc_x < hi_x);
  assign in_void   = bank_in(bank, 8'(VOID_LO), 8'(VOID_HI));
  assign in_ram    = bank_in(bank, 8'(RAM_FIRST), 8'(RAM_LAST));
  assign above_ram = int'(bank) > RAM_LAST;

  // Priority: cache window, forbidden ranges, RAM enable, ROM enable
  always_comb begin
    if (!req)                     verdict = VERD_NONE;
    else if (in_window)           verdict = VERD_GRANT;
    else if (in_void || above_ram) verdict = VERD_DENY;
    else if (in_ram)              verdict = ram_en ? VERD_GRANT : VERD_DENY;
    else                          verdict = rom_en ? VERD_GRANT : VERD_DENY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= 1'b0;
      ok      <= 1'b0;
      go_clr  <= 1'b0;
      irq_clr <= 1'b0;
    end else begin
      vld     <= (verdict != VERD_NONE);
      ok      <= (verdict == VERD_GRANT);
      go_clr  <= (verdict == VERD_DENY);
      irq_clr <= (verdict == VERD_GRANT);
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    vld |-> (go_clr != irq_clr) && (ok == irq_clr));
  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !vld && !go_clr && !irq_clr && !ok);
  // R8
  window_chk: assert property (@(posedge clk) disable iff (rst)
    (req && cache_on && (pc >= cbase) && ({1'b0, pc} < {1'b0, cbase} + 17'd512)) |=> ok);
  // R9
  forbid_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !cache_on && (bank >= 8'h74 || (bank[7:4] == 4'h6))) |=> go_clr);
  // R10
  ram_need_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !cache_on && (bank[7:2] == 6'b011100) && !ram_en) |=> !ok);
endmodule

// File: rtl/prog_bank_mapper.sv
module prog_bank_mapper #(
  parameter int BANK_W      = 8,
  parameter int OFF_W       = 16,
  parameter int ROM_CNT_W   = 6,
  parameter int RAM_CNT_W   = 3,
  parameter int ROM_MAX     = 32,
  parameter int RAM_MAX     = 4,
  parameter int RAM_FIRST   = 'h70,
  parameter int CACHE_BYTES = 512,
  localparam int PHYS_W     = OFF_W + $clog2(2 * ROM_MAX) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROM_CNT_W-1:0] rom_bank_cnt,
  input  logic [RAM_CNT_W-1:0] ram_bank_cnt,
  input  logic                 map_req,
  input  logic [BANK_W-1:0]    map_bank,
  input  logic [OFF_W-1:0]     map_offset,
  output logic                 map_vld,
  output logic [PHYS_W-1:0]    map_addr,
  output logic                 map_is_ram,
  input  logic                 st_req,
  input  logic [BANK_W-1:0]    st_bank,
  input  logic [OFF_W-1:0]     st_pc,
  input  logic [OFF_W-1:0]     cache_base,
  input  logic                 cache_on,
  input  logic                 scr_rom_en,
  input  logic                 scr_ram_en,
  output logic                 st_vld,
  output logic                 st_ok,
  output logic                 go_clr,
  output logic                 irq_clr
);
  pbm_addr_map #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .ROM_CNT_W(ROM_CNT_W), .RAM_CNT_W(RAM_CNT_W),
    .ROM_MAX(ROM_MAX), .RAM_MAX(RAM_MAX), .RAM_FIRST(RAM_FIRST)
  ) u_map (
    .clk(clk), .rst(rst), .rom_cnt(rom_bank_cnt), .ram_cnt(ram_bank_cnt),
    .req(map_req), .bank(map_bank), .offset(map_offset),
    .vld(map_vld), .addr(map_addr), .is_ram(map_is_ram)
  );

  pbm_start_gate #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .CACHE_BYTES(CACHE_BYTES),
    .RAM_FIRST(RAM_FIRST), .RAM_MAX(RAM_MAX)
  ) u_gate (
    .clk(clk), .rst(rst), .req(st_req), .bank(st_bank), .pc(st_pc),
    .cbase(cache_base), .cache_on(cache_on), .rom_en(scr_rom_en), .ram_en(scr_ram_en),
    .vld(st_vld), .ok(st_ok), .go_clr(go_clr), .irq_clr(irq_clr)
  );
endmodule

// File: tb/prog_bank_mapper_tb_top.sv
module prog_bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  rom_bank_cnt = '0;
  logic [2:0]  ram_bank_cnt = '0;
  logic        map_req = 1'b0;
  logic [7:0]  map_bank = '0;
  logic [15:0] map_offset = '0;
  logic        map_vld;
  logic [22:0] map_addr;
  logic        map_is_ram;
  logic        st_req = 1'b0;
  logic [7:0]  st_bank = '0;
  logic [15:0] st_pc = '0;
  logic [15:0] cache_base = '0;
  logic        cache_on = 1'b0;
  logic        scr_rom_en = 1'b0;
  logic        scr_ram_en = 1'b0;
  logic        st_vld, st_ok, go_clr, irq_clr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_bank_mapper dut_i (
    .clk(clk), .rst(rst), .rom_bank_cnt(rom_bank_cnt), .ram_bank_cnt(ram_bank_cnt),
    .map_req(map_req), .map_bank(map_bank), .map_offset(map_offset),
    .map_vld(map_vld), .map_addr(map_addr), .map_is_ram(map_is_ram),
    .st_req(st_req), .st_bank(st_bank), .st_pc(st_pc), .cache_base(cache_base),
    .cache_on(cache_on), .scr_rom_en(scr_rom_en), .scr_ram_en(scr_ram_en),
    .st_vld(st_vld), .st_ok(st_ok), .go_clr(go_clr), .irq_clr(irq_clr)
  );

  typedef struct packed {
    logic [7:0]  bank;
    logic [15:0] off;
    logic [5:0]  rom;
    logic [2:0]  ram;
    logic [22:0] addr;
    logic        isr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'h45, 16'h1234, 6'd8,  3'd2, 23'h051234, 1'b0},  // R1
    '{8'hC5, 16'h1234, 6'd8,  3'd2, 23'h051234, 1'b0},  // R4
    '{8'h41, 16'hFFFF, 6'd1,  3'd2, 23'h01FFFF, 1'b0},  // R2
    '{8'h40, 16'h0000, 6'd1,  3'd2, 23'h000000, 1'b0},  // R2
    '{8'h7F, 16'h0010, 6'd40, 3'd2, 23'h1F0010, 1'b0},  // R5
    '{8'h05, 16'h8000, 6'd2,  3'd2, 23'h218000, 1'b0},  // R3
    '{8'h3F, 16'hABCD, 6'd32, 3'd2, 23'h5FABCD, 1'b0},  // R3
    '{8'h3F, 16'hABCD, 6'd40, 3'd2, 23'h5FABCD, 1'b0},  // R5
    '{8'h72, 16'h0100, 6'd8,  3'd2, 23'h000100, 1'b1},  // R6
    '{8'h73, 16'h0200, 6'd8,  3'd3, 23'h000200, 1'b1},  // R6
    '{8'h73, 16'h0200, 6'd8,  3'd4, 23'h030200, 1'b1},  // R6
    '{8'h71, 16'h0200, 6'd8,  3'd7, 23'h010200, 1'b1},  // R6
    '{8'hF1, 16'h0200, 6'd8,  3'd4, 23'h010200, 1'b0},  // R4
    '{8'h45, 16'h1234, 6'd0,  3'd2, 23'h011234, 1'b0},  // R5
    '{8'h10, 16'h1234, 6'd3,  3'd2, 23'h241234, 1'b0},  // R3
    '{8'h50, 16'h1234, 6'd3,  3'd2, 23'h021234, 1'b0},  // R1
    '{8'h73, 16'h0200, 6'd8,  3'd0, 23'h000200, 1'b1}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_case(input logic [7:0] b, input logic [15:0] pc, input logic [15:0] base,
                            input logic con, input logic rom, input logic ram,
                            input logic exp_ok, input string req);
    @(negedge clk);
    st_req = 1'b1; st_bank = b; st_pc = pc; cache_base = base;
    cache_on = con; scr_rom_en = rom; scr_ram_en = ram;
    @(negedge clk);
    st_req = 1'b0;
    chk({req, " vld"}, 32'(st_vld), 32'd1);
    chk({req, " ok"}, 32'(st_ok), 32'(exp_ok));
    chk({req, " R11 go_clr"}, 32'(go_clr), 32'(!exp_ok));
    chk({req, " R11 irq_clr"}, 32'(irq_clr), 32'(exp_ok));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 / R11 reset state
    chk("R7 reset map_vld", 32'(map_vld), 32'd0);
    chk("R7 reset map_addr", 32'(map_addr), 32'd0);
    chk("R11 reset st_vld", 32'(st_vld), 32'd0);
    chk("R11 reset go_clr", 32'(go_clr), 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      map_req = 1'b1; map_bank = VEC[i].bank; map_offset = VEC[i].off;
      rom_bank_cnt = VEC[i].rom; ram_bank_cnt = VEC[i].ram;
      @(negedge clk);
      map_req = 1'b0;
      chk($sformatf("R7 vec%0d vld", i), 32'(map_vld), 32'd1);
      chk($sformatf("map vec%0d addr", i), 32'(map_addr), 32'(VEC[i].addr));
      chk($sformatf("map vec%0d is_ram", i), 32'(map_is_ram), 32'(VEC[i].isr));
    end
    @(negedge clk);
    chk("R7 vld drops", 32'(map_vld), 32'd0);

    // R8 cache window
    start_case(8'h65, 16'h11FF, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b1, "R8 top of window");
    start_case(8'h65, 16'h1000, 16'h1000, 1'b1, 1'b0, 1'b0, 1'b1, "R8 window base");
    start_case(8'h65, 16'h1200, 16'h1000, 1'b1, 1'b1, 1'b1, 1'b0, "R9 past window");
    start_case(8'h65, 16'h0FFF, 16'h1000, 1'b1, 1'b1, 1'b1, 1'b0, "R9 below window");
    start_case(8'h65, 16'h1100, 16'h1000, 1'b0, 1'b1, 1'b1, 1'b0, "R8 cache off");
    start_case(8'h99, 16'hFFFF, 16'hFF00, 1'b1, 1'b0, 1'b0, 1'b1, "R8 window at top");
    start_case(8'h99, 16'h0050, 16'hFF00, 1'b1, 1'b1, 1'b1, 1'b0, "R8 no wrap");
    // R9 forbidden banks
    start_case(8'h60, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, "R9 bank 60");
    start_case(8'h6F, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, "R9 bank 6F");
    start_case(8'h74, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, "R9 bank 74");
    start_case(8'hC0, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, "R9 bank C0");
    start_case(8'h5F, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R10 bank 5F rom");
    // R10 enable bits
    start_case(8'h70, 16'h0000, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, "R10 ram off");
    start_case(8'h70, 16'h0000, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b1, "R10 ram on");
    start_case(8'h73, 16'h0000, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b1, "R10 bank 73");
    start_case(8'h10, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, "R10 rom off");
    start_case(8'h10, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R10 rom on");

    @(negedge clk);
    chk("R11 idle st_vld", 32'(st_vld), 32'd0);
    chk("R11 idle irq_clr", 32'(irq_clr), 32'd0);
    chk("R11 idle go_clr", 32'(go_clr), 32'd0);
    finish_run();
  end
endmodule